// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address bits that walk a synchronous pipelined memory through a four-beat burst. A load strobe captures a full word address; its two lowest bits become the first beat of the burst. Each rising clock edge that samples the active-low advance input low moves the burst one beat further.

A static order input selects the beat order. In linear order the low bits count upward and wrap within their group of four. In interleaved order each beat is the start bits XOR-ed with the beat number. The upper address bits come from the load and are held unchanged. The full word address is put back together from those held bits and the current burst bits. The sequencing does not depend on whether the burst reads or writes.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, the beat count and the stored address are cleared, so `burst_addr_o` and `word_addr_o` read zero.
- R2: In the cycle after `load_i` is sampled high, `word_addr_o` equals the loaded `start_addr_i` and `burst_addr_o` equals its bits [1:0].
- R3: With `mode_i` = 1 (interleaved), the address at beat k after a load is (start[1:0] XOR k); for example, start 01 gives 01, 00, 11, 10.
- R4: With `mode_i` = 0 (linear), the address at beat k after a load is (start[1:0] + k) mod 4; for example, start 11 gives 11, 00, 01, 10.
- R5: The beat count moves forward by one only on a rising edge where `adv_n_i` is sampled low. When `adv_n_i` is high, both outputs keep their values.
- R6: When `load_i` and a low `adv_n_i` are sampled on the same edge, the load takes priority and the beat count restarts at zero.
- R7: Bits of `word_addr_o` above bit 1 equal the upper bits of the last loaded address and do not change until the next load.
- R8: After the fourth beat, further advances wrap within the same four-address group. The fifth beat repeats the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Captures the start address and begins a burst |
| start_addr_i | input | ADDR_W | Full starting word address |
| adv_n_i | input | 1 | Advance to the next beat when low |
| mode_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| burst_addr_o | output | 2 | Current low-order burst address |
| word_addr_o | output | ADDR_W | Held upper bits joined with the burst address |

## Verification
The assertions treat `mode_i` as constant for the length of a burst. The property that compares consecutive linear beats requires the order to be linear in both cycles it looks at. The stimulus changes `mode_i` only in the same cycle as a load. It covers runs of advance longer than four beats, idle cycles with advance high between beats, and loads that coincide with an advance. A behavioural model in the bench predicts both outputs after every edge.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes nothing beyond a two-valued order selection.
package burst_seq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bseq_beat_counter.sv
// Beat counter: counts the beats taken since the last load and wraps
// modulo 2**BEAT_W. Assumes load_i and adv_n_i are synchronous to clk.
module bseq_beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    output logic [BEAT_W-1:0] beat_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

    // Purpose: clear on reset or load (load wins over advance), else step when advance is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_o <= '0;
        end else if (load_i) begin
            beat_o <= '0;
        end else if (!adv_n_i) begin
            beat_o <= beat_o + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> beat_o == '0);

    p_hold_no_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(beat_o));

    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> beat_o == '0);

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && beat_o == LAST_BEAT) |=> beat_o == '0);
endmodule

// File: rtl/bseq_base_reg.sv
// Base address register: captures the full start address on load and
// holds it for the rest of the burst. Assumes load_i is synchronous to clk.
module bseq_base_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o
);
    // Purpose: take a new base address on load and otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
        end else if (load_i) begin
            base_o <= addr_i;
        end
    end

    p_base_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(base_o));
endmodule

// File: rtl/bseq_order_map.sv
// Order mapper: turns a start offset and beat number into the burst
// address, by XOR (interleaved) or by modular add (linear).
// Purely combinational; assumes order_i is static during a burst.
module bseq_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  burst_order_e      order_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] addr_o
);
    // Purpose: pick the address formula for the selected order.
    always_comb begin
        case (order_i)
            ORD_INTERLEAVE: addr_o = start_i ^ beat_i;
            default:        addr_o = start_i + beat_i;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top: joins the base register, the beat counter
// and the order mapper into the word address that walks the burst.
// Assumes mode_i changes only when a new burst is loaded.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [1:0]        burst_addr_o,
    output logic [ADDR_W-1:0] word_addr_o
);
    localparam int BEAT_W = 2;

    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base;
    burst_order_e      order;

    assign order = burst_order_e'(mode_i);

    bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .addr_i (start_addr_i),
        .base_o (base)
    );

    bseq_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat)
    );

    bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order_i (order),
        .start_i (base[BEAT_W-1:0]),
        .beat_i  (beat),
        .addr_o  (burst_addr_o)
    );

    // Purpose: rebuild the full word address from held upper bits and burst bits.
    always_comb begin
        word_addr_o = {base[ADDR_W-1:BEAT_W], burst_addr_o};
    end

    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> word_addr_o == $past(start_addr_i));

    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !mode_i) ##1 !mode_i |-> burst_addr_o == $past(burst_addr_o) + 2'd1);

    p_interleave_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i) ##1 (!load_i && !adv_n_i && mode_i) ##1 mode_i
        |-> burst_addr_o == ($past(burst_addr_o) ^ 2'd1));
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_i;
    logic [AW-1:0] start_addr_i;
    logic          adv_n_i;
    logic          mode_i;
    logic [1:0]    burst_addr_o;
    logic [AW-1:0] word_addr_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    int m_start = 0;
    int m_beat  = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .start_addr_i (start_addr_i),
        .adv_n_i      (adv_n_i),
        .mode_i       (mode_i),
        .burst_addr_o (burst_addr_o),
        .word_addr_o  (word_addr_o)
    );

    function automatic int exp_burst();
        int s = m_start % 4;
        int k = m_beat % 4;
        if (mode_i) return s ^ k;
        return (s + k) % 4;
    endfunction

    task automatic check(string tag);
        int eb = exp_burst();
        int ew = (m_start & ~3) | eb;
        total++;
        if (int'(burst_addr_o) != eb || int'(word_addr_o) != ew) begin
            bad++;
            $display("FAIL %s: burst=%0d word=%h expected burst=%0d word=%h",
                     tag, burst_addr_o, word_addr_o, eb, ew[AW-1:0]);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit ld, input int addr, input bit advn, input bit md, input string tag);
        load_i       = ld;
        start_addr_i = addr[AW-1:0];
        adv_n_i      = advn;
        mode_i       = md;
        @(posedge clk);
        if (!rst_n) begin
            m_start = 0; m_beat = 0;
        end else if (ld) begin
            m_start = addr & ((1 << AW) - 1); m_beat = 0;
        end else if (!advn) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load_i = 1'b0; start_addr_i = '0; adv_n_i = 1'b1; mode_i = 1'b0;
        @(negedge clk);
        step(1'b1, 'h1234, 1'b0, 1'b0, "R1 reset");
        step(1'b0, 0, 1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;

        // R2/R4/R8: linear from 11, run six beats
        step(1'b1, 'hABCF, 1'b1, 1'b0, "R2 load");
        for (int i = 0; i < 6; i++) step(1'b0, 'h5555, 1'b0, 1'b0, "R4 R8 linear wrap");

        // R3: interleaved from 01 and 10
        step(1'b1, 'h0F01, 1'b1, 1'b1, "R2 load");
        for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b0, 1'b1, "R3 R8 interleave");
        step(1'b1, 'h7FF2, 1'b1, 1'b1, "R2 load");
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 1'b1, "R3 interleave");

        // R5: idle cycles between beats, R7 upper bits steady
        step(1'b1, 'hC3C0, 1'b1, 1'b0, "R2 load");
        step(1'b0, 'hFFFF, 1'b1, 1'b0, "R5 hold");
        step(1'b0, 'hFFFF, 1'b1, 1'b0, "R5 hold");
        step(1'b0, 'hFFFF, 1'b0, 1'b0, "R5 step");
        step(1'b0, 'h0000, 1'b1, 1'b0, "R5 R7 hold");
        step(1'b0, 'h0000, 1'b0, 1'b0, "R7 step");

        // R6: load with advance low restarts at beat zero
        step(1'b1, 'h1112, 1'b0, 1'b1, "R6 load priority");
        step(1'b0, 0, 1'b0, 1'b1, "R6 after load");
        step(1'b1, 'h2223, 1'b0, 1'b0, "R6 load priority");
        step(1'b0, 0, 1'b0, 1'b0, "R6 after load");

        // mixed pattern
        for (int i = 0; i < 40; i++)
            step((i % 7) == 0, i * 37 + 5, (i % 3) == 1, (i / 7) % 2, "R3 R4 R5 mixed");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule